// File: doc/BRIEF.md
# Floating-Point Status Flag Register

This block keeps the exception status of a single-precision arithmetic unit. Each time the datapath finishes an operation, it raises `op_done` together with one-cycle exception strobes. The block turns those strobes into five sticky flags and one summary flag. The sticky flags are invalid, overflow, divide-by-zero, underflow and inexact. The summary flag is rewritten on every completion and describes only the operation that just finished.

Software can also load the flags directly with a 16-bit update operand. The operand holds value bits and mask bits in fixed positions. Five of the flags are loaded with value AND mask. The inexact flag behaves differently: it is written only when its mask bit is set and otherwise keeps its current value.

All flags are registered and appear on the outputs one clock after the stimulus. The next value of the flag vector comes from one of three named sources:
- `SRC_HOLD`: no event in this cycle, so every flag keeps its value.
- `SRC_OP`: an operation completed. The summary flag is rewritten and the sticky flags are OR-ed with the mapped exceptions.
- `SRC_SW`: an update write, loaded from the operand.

The source is chosen fresh every cycle, in the order `SRC_SW` over `SRC_OP` over `SRC_HOLD`. Any source can follow any other. Reset forces every flag to zero.

Top module: `fpflag_reg`

## Requirements
- R1: A synchronous active-high `rst` clears all six flags to 0 at the next rising edge.
- R2: On a completion, `exc_invalid` sets `flag_invalid`, `exc_overflow` sets `flag_overflow` and `exc_divzero` sets `flag_divzero`.
- R3: On a completion, `exc_underflow` or `exc_out_denorm` sets `flag_underflow`.
- R4: On a completion, `exc_inexact` or `exc_out_denorm` sets `flag_inexact`, so a single output-denormal event sets both `flag_underflow` and `flag_inexact`.
- R5: `exc_in_denorm` is ignored completely. A completion that carries only this strobe sets no flag and leaves `flag_summary` at 0.
- R6: On each completion without an update write, `flag_summary` becomes 1 if any of invalid, overflow, underflow, divide-by-zero, inexact or output-denormal was strobed, and 0 otherwise.
- R7: The sticky flags are never cleared by completions. In a cycle with neither `op_done` nor `upd_en`, all flags keep their value.
- R8: When `upd_en` is high, the flags are loaded as follows: `flag_summary` = operand[7] & operand[15], `flag_invalid` = operand[6] & operand[14], `flag_overflow` = operand[5] & operand[13], `flag_divzero` = operand[4] & operand[12], and `flag_underflow` = operand[3] & operand[11]. A clear mask bit therefore clears its flag.
- R9: During an update write, `flag_inexact` takes operand[2] when operand[10] is 1 and keeps its old value when operand[10] is 0.
- R10: When `upd_en` and `op_done` are high in the same cycle, only the update write takes effect.
- R11: Operand bits 0, 1, 8 and 9 have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_done | input | 1 | An operation completed this cycle |
| exc_invalid | input | 1 | Invalid-operation strobe |
| exc_overflow | input | 1 | Overflow strobe |
| exc_underflow | input | 1 | Underflow strobe |
| exc_divzero | input | 1 | Divide-by-zero strobe |
| exc_inexact | input | 1 | Inexact-result strobe |
| exc_out_denorm | input | 1 | Result-was-denormal strobe |
| exc_in_denorm | input | 1 | Operand-was-denormal strobe (ignored) |
| upd_en | input | 1 | Software update write this cycle |
| upd_operand | input | 16 | Value bits [7:2], mask bits [15:10] |
| flag_summary | output | 1 | Non-sticky summary of the last operation |
| flag_invalid | output | 1 | Sticky invalid flag |
| flag_overflow | output | 1 | Sticky overflow flag |
| flag_divzero | output | 1 | Sticky divide-by-zero flag |
| flag_underflow | output | 1 | Sticky underflow flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
Every flag is a direct register output, so a wrong internal value shows at the ports one clock after the event that caused it. It then stays visible until the next update write or reset. A wrongly cleared sticky flag, or a summary flag that wrongly stays set, is exposed by the very next completion the bench checks. Errors in the inexact mask-keep rule or in the update-write priority show in the cycle right after the write. The bench therefore compares the full flag vector after every cycle against a reference model.

// File: rtl/fpflag_pkg.sv
package fpflag_pkg;

    // Flag vector, index order matches the operand bit pairing:
    // index i pairs with value bit VAL_LSB+i and mask bit MASK_LSB+i.
    localparam int NFLAG    = 6;
    localparam int UPD_W    = 16;
    localparam int VAL_LSB  = 2;
    localparam int MASK_LSB = 10;

    localparam int IDX_FX = 0;
    localparam int IDX_FU = 1;
    localparam int IDX_FZ = 2;
    localparam int IDX_FV = 3;
    localparam int IDX_FI = 4;
    localparam int IDX_FS = 5;

    typedef logic [NFLAG-1:0] flagvec_t;

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic divzero;
        logic inexact;
        logic out_denorm;
        logic in_denorm;
    } exc_t;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_OP   = 2'd1,
        SRC_SW   = 2'd2
    } src_e;

endpackage

// File: rtl/fpflag_exc_map.sv
module fpflag_exc_map
    import fpflag_pkg::*;
(
    input  exc_t     exc,
    output flagvec_t raise
);
    logic any_exc;
    logic unused_in_denorm;

    assign unused_in_denorm = exc.in_denorm;

    always_comb begin
        raise          = '0;
        raise[IDX_FI]  = exc.invalid;
        raise[IDX_FV]  = exc.overflow;
        raise[IDX_FZ]  = exc.divzero;
        raise[IDX_FU]  = exc.underflow | exc.out_denorm;
        raise[IDX_FX]  = exc.inexact   | exc.out_denorm;
        any_exc        = |raise[IDX_FI:IDX_FX];
        raise[IDX_FS]  = any_exc;
    end
endmodule

// File: rtl/fpflag_upd_decode.sv
module fpflag_upd_decode
    import fpflag_pkg::*;
(
    input  logic [UPD_W-1:0] operand,
    input  flagvec_t         cur,
    output flagvec_t         load
);
    logic unused_bits;
    assign unused_bits = ^{operand[VAL_LSB-1:0], operand[MASK_LSB-1:VAL_LSB+NFLAG]};

    for (genvar i = 0; i < NFLAG; i++) begin : g_pair
        if (i == IDX_FX) begin : g_keep
            assign load[i] = operand[MASK_LSB+i] ? operand[VAL_LSB+i] : cur[i];
        end else begin : g_and
            assign load[i] = operand[VAL_LSB+i] & operand[MASK_LSB+i];
        end
    end
endmodule

// File: rtl/fpflag_store.sv
module fpflag_store
    import fpflag_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     op_done,
    input  logic     upd_en,
    input  flagvec_t raise,
    input  flagvec_t load,
    output flagvec_t flags
);
    src_e     src;
    flagvec_t nxt;
    flagvec_t sticky_mask;

    assign sticky_mask = ~(flagvec_t'(1) << IDX_FS);

    always_comb begin
        if (upd_en)       src = SRC_SW;
        else if (op_done) src = SRC_OP;
        else              src = SRC_HOLD;
    end

    always_comb begin
        unique case (src)
            SRC_SW:   nxt = load;
            SRC_OP:   nxt = ((flags | raise) & sticky_mask) | (raise & ~sticky_mask);
            SRC_HOLD: nxt = flags;
            default:  nxt = flags;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end
endmodule

// File: rtl/fpflag_reg.sv
module fpflag_reg
    import fpflag_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_done,
    input  logic        exc_invalid,
    input  logic        exc_overflow,
    input  logic        exc_underflow,
    input  logic        exc_divzero,
    input  logic        exc_inexact,
    input  logic        exc_out_denorm,
    input  logic        exc_in_denorm,
    input  logic        upd_en,
    input  logic [15:0] upd_operand,
    output logic        flag_summary,
    output logic        flag_invalid,
    output logic        flag_overflow,
    output logic        flag_divzero,
    output logic        flag_underflow,
    output logic        flag_inexact
);
    exc_t     exc;
    flagvec_t raise;
    flagvec_t load;
    flagvec_t flags;

    assign exc = '{invalid:    exc_invalid,
                   overflow:   exc_overflow,
                   underflow:  exc_underflow,
                   divzero:    exc_divzero,
                   inexact:    exc_inexact,
                   out_denorm: exc_out_denorm,
                   in_denorm:  exc_in_denorm};

    fpflag_exc_map u_map (
        .exc   (exc),
        .raise (raise)
    );

    fpflag_upd_decode u_dec (
        .operand (upd_operand),
        .cur     (flags),
        .load    (load)
    );

    fpflag_store u_store (
        .clk     (clk),
        .rst     (rst),
        .op_done (op_done),
        .upd_en  (upd_en),
        .raise   (raise),
        .load    (load),
        .flags   (flags)
    );

    assign flag_summary   = flags[IDX_FS];
    assign flag_invalid   = flags[IDX_FI];
    assign flag_overflow  = flags[IDX_FV];
    assign flag_divzero   = flags[IDX_FZ];
    assign flag_underflow = flags[IDX_FU];
    assign flag_inexact   = flags[IDX_FX];

    logic op_only;
    assign op_only = op_done && !upd_en;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (flags == '0)); // R1

    AST_INVALID_SETS: assert property (@(posedge clk) disable iff (rst)
        (op_only && exc_invalid) |=> flag_invalid); // R2

    AST_OD_SETS_FU: assert property (@(posedge clk) disable iff (rst)
        (op_only && exc_out_denorm) |=> flag_underflow); // R3

    AST_OD_SETS_FX: assert property (@(posedge clk) disable iff (rst)
        (op_only && exc_out_denorm) |=> flag_inexact); // R4

    AST_INDENORM_QUIET: assert property (@(posedge clk) disable iff (rst)
        (op_only && exc_in_denorm && !exc_invalid && !exc_overflow && !exc_underflow
         && !exc_divzero && !exc_inexact && !exc_out_denorm) |=> !flag_summary); // R5

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        op_only |=> ((flag_invalid || !$past(flag_invalid)) && (flag_overflow || !$past(flag_overflow))
                     && (flag_divzero || !$past(flag_divzero)) && (flag_underflow || !$past(flag_underflow))
                     && (flag_inexact || !$past(flag_inexact)))); // R7

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!op_done && !upd_en) |=> $stable(flags)); // R7

    AST_MASK_CLEARS_FS: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_operand[15]) |=> !flag_summary); // R8

    AST_FX_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
        (upd_en && !upd_operand[10]) |=> $stable(flag_inexact)); // R9

    AST_UPD_WINS: assert property (@(posedge clk) disable iff (rst)
        (upd_en && op_done && !upd_operand[14]) |=> !flag_invalid); // R10
endmodule

// File: tb/sim_fpflag_reg.sv
module sim_fpflag_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_done = 1'b0;
    logic [6:0]  exc = '0;   // {inv, ovf, unf, dz, inx, odn, idn}
    logic        upd_en = 1'b0;
    logic [15:0] upd_operand = '0;
    logic        f_s, f_i, f_v, f_z, f_u, f_x;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [5:0] model = '0; // {FS,FI,FV,FZ,FU,FX}

    always #5 clk = ~clk;

    fpflag_reg u0 (
        .clk(clk), .rst(rst), .op_done(op_done),
        .exc_invalid(exc[6]), .exc_overflow(exc[5]), .exc_underflow(exc[4]),
        .exc_divzero(exc[3]), .exc_inexact(exc[2]), .exc_out_denorm(exc[1]),
        .exc_in_denorm(exc[0]), .upd_en(upd_en), .upd_operand(upd_operand),
        .flag_summary(f_s), .flag_invalid(f_i), .flag_overflow(f_v),
        .flag_divzero(f_z), .flag_underflow(f_u), .flag_inexact(f_x));

    function automatic logic [5:0] ref_next(logic [5:0] cur, logic r, logic od,
                                            logic [6:0] e, logic ue, logic [15:0] w);
        logic [5:0] n;
        logic fi, fv, fu, fz, fx;
        if (r) return 6'b0;
        if (ue) begin
            n[5] = w[7] & w[15];
            n[4] = w[6] & w[14];
            n[3] = w[5] & w[13];
            n[2] = w[4] & w[12];
            n[1] = w[3] & w[11];
            n[0] = w[10] ? w[2] : cur[0];
            return n;
        end
        if (!od) return cur;
        fi = e[6]; fv = e[5]; fz = e[3];
        fu = e[4] | e[1];
        fx = e[2] | e[1];
        n[4] = cur[4] | fi;
        n[3] = cur[3] | fv;
        n[2] = cur[2] | fz;
        n[1] = cur[1] | fu;
        n[0] = cur[0] | fx;
        n[5] = fi | fv | fz | fu | fx;
        return n;
    endfunction

    task automatic step(input logic r, input logic od, input logic [6:0] e,
                        input logic ue, input logic [15:0] w, input string tag);
        logic [5:0] got;
        rst = r; op_done = od; exc = e; upd_en = ue; upd_operand = w;
        @(posedge clk);
        model = ref_next(model, r, od, e, ue, w);
        @(negedge clk);
        got = {f_s, f_i, f_v, f_z, f_u, f_x};
        n_chk++;
        if (got !== model) begin
            n_bad++;
            $display("FAIL %s: flags got %b expected %b", tag, got, model);
        end
        rst = 1'b0; op_done = 1'b0; exc = '0; upd_en = 1'b0; upd_operand = '0;
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0, 7'h00, 1'b0, 16'h0000, "R1 reset");
        step(1'b0, 1'b1, 7'b0000001, 1'b0, 16'h0000, "R5 input-denormal alone");
        step(1'b0, 1'b1, 7'b0000010, 1'b0, 16'h0000, "R3 R4 output-denormal sets FU and FX");
        step(1'b0, 1'b1, 7'b0000000, 1'b0, 16'h0000, "R6 clean op clears summary");
        step(1'b0, 1'b1, 7'b1000000, 1'b0, 16'h0000, "R2 invalid");
        step(1'b0, 1'b1, 7'b0100000, 1'b0, 16'h0000, "R2 overflow");
        step(1'b0, 1'b1, 7'b0001000, 1'b0, 16'h0000, "R2 divzero");
        step(1'b0, 1'b0, 7'b1111110, 1'b0, 16'h0000, "R7 strobes without op_done held");
        step(1'b0, 1'b1, 7'b0000000, 1'b0, 16'h0000, "R7 sticky survive clean op");
        step(1'b0, 1'b0, 7'h00, 1'b1, 16'h00FC, "R8 clear masks clear flags, R9 FX kept");
        step(1'b0, 1'b0, 7'h00, 1'b1, 16'hFCFC, "R8 full mask sets all");
        step(1'b0, 1'b0, 7'h00, 1'b1, 16'h0400, "R9 FX mask set loads 0");
        step(1'b0, 1'b0, 7'h00, 1'b1, 16'h0404, "R9 FX mask set loads 1");
        step(1'b0, 1'b1, 7'b1111110, 1'b1, 16'h0000, "R10 update beats op");
        step(1'b0, 1'b0, 7'h00, 1'b1, 16'h0303, "R11 bits 0 1 8 9 ignored");
        step(1'b0, 1'b1, 7'b0010000, 1'b0, 16'h0000, "R3 underflow");
        step(1'b0, 1'b1, 7'b0000100, 1'b0, 16'h0000, "R4 inexact");
        step(1'b1, 1'b1, 7'b1111111, 1'b1, 16'hFFFF, "R1 reset over everything");
        void'($urandom(32'd12345));
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[31:30] == 2'b00 && rv[29:26] == 4'h0, rv[0] | rv[1], rv[8:2],
                 rv[11:9] == 3'b000, rv[27:12], "random R6 R7 R8");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule